// File: doc/BRIEF.md
# Processor Exception Control Unit

This block holds the exception state of a simple single-issue processor and sequences entry into and return from exceptions. It keeps three 32-bit control registers: a Status word at index 12, a Cause word at index 13, and an exception return address at index 14. At every instruction boundary it looks at a synchronous trap request, which carries a 5-bit code, and at an external interrupt line. If it takes an exception, it records the cause and the return address, switches to kernel mode with interrupts masked, and asks the fetch stage to redirect to a fixed handler address.

Software reads the registers through a combinational move-from port. It writes them through a move-to strobe, which only reaches the bits that software may write. A return-from-exception strobe restores the saved mode and enable bits and redirects fetch to the stored return address. A trap is taken at the faulting instruction. An interrupt is taken at the next boundary, and only while the current enable bit is set. When both arrive on the same boundary, the trap is taken and the interrupt stays pending.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, Status, Cause and the return-address register read 0, so the core is in kernel mode with interrupts disabled, and `redirect` is low.
- R2: When `boundary` and `trapReq` are high at a clock edge, the following happens at that edge. Cause bits 6..2 take `trapCode` (examples: 0 interrupt, 4 illegal load address, 8 syscall, 12 overflow). The return-address register takes `curPc`. Status bits 3..2 take the old Status bits 1..0. Status bits 1..0 become 0 (bit 1 is the mode bit with user=1; bit 0 is the interrupt enable with enabled=1).
- R3: When `boundary` and `intReq` are high, `trapReq` is low and Status bit 0 is 1, an interrupt is taken. Cause bits 6..2 become 0, the return-address register takes `nextPc`, and Status is updated as in R2.
- R4: While Status bit 0 is 0, `intReq` has no effect on any register or on `redirect`.
- R5: If a trap and an interrupt arrive on the same boundary, only the trap is recorded. An interrupt held on `intReq` is taken at a later boundary, once Status bit 0 is 1 again.
- R6: When `eretReq` is high and no exception is taken, Status bits 1..0 take Status bits 3..2, bits 3..2 keep their value, and the next cycle redirects to the return-address register.
- R7: `rdData` returns Status for `regIdx`=12, Cause for 13 and the return address for 14, and 0 for any other index. Status bits 31..4 and Cause bits other than 9..8 and 6..2 always read 0.
- R8: A move-to (`wrEn`) at index 12 writes Status bits 3..0. At index 13 it writes only Cause bits 9..8. At index 14 it writes all 32 bits. Writes to other indices change nothing.
- R9: `redirect` is high for exactly the one cycle after each edge where an exception or a return is taken. `redirectPc` is 0x8000_0080 after an exception and the return address after a return. With neither taken, `redirect` is low.
- R10: An exception taken at an edge overrides both a move-to and a return requested at the same edge, and a return overrides a move-to. An overridden request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | An instruction boundary occurs this cycle |
| curPc | input | 32 | PC of the instruction at the boundary |
| nextPc | input | 32 | PC of the next instruction not yet executed |
| trapReq | input | 1 | Synchronous trap from the current instruction |
| trapCode | input | 5 | Exception code for the trap |
| intReq | input | 1 | External interrupt request level |
| eretReq | input | 1 | Return-from-exception strobe |
| wrEn | input | 1 | Move-to register strobe |
| regIdx | input | 5 | Register index for read and write |
| wrData | input | 32 | Move-to data |
| rdData | output | 32 | Move-from data for `regIdx` |
| redirect | output | 1 | One-cycle fetch redirect |
| redirectPc | output | 32 | Target address of the redirect |

## Verification
Two conflicts can occur in one cycle, and the bench provokes both. The first is a trap and an enabled interrupt at the same boundary. The second is an exception together with a move-to or return strobe. A directed sequence first sets the interrupt enable. It then raises a trap, an interrupt, a move-to into the return-address register and a return all at once. The test checks that only the trap's code and PC were recorded. It then checks that the held interrupt is taken only after the return re-enables interrupts. Random cycles mix all strobes at high rates, and a bench reference model applies the stated priorities and judges each result.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // Strobes from control to the register datapath
  typedef struct packed {
    logic takeExc;
    logic excIsInt;
    logic doEret;
    logic wrStatus;
    logic wrCause;
    logic wrEpc;
  } excStrobes_t;
endpackage

// File: rtl/exc_ctl.sv
module exc_ctl
  import exc_pkg::*;
#(
  parameter int IDX_W      = 5,
  parameter int STATUS_IDX = 12,
  parameter int CAUSE_IDX  = 13,
  parameter int EPC_IDX    = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             boundary,
  input  logic             trapReq,
  input  logic             intReq,
  input  logic             eretReq,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] regIdx,
  input  logic             ieQ,
  output excStrobes_t      st,
  output logic             redirect,
  output logic             redirectIsEret
);
  logic takeTrap, takeInt, wrOk;

  always_comb begin
    takeTrap    = boundary & trapReq;
    takeInt     = boundary & intReq & ieQ & ~trapReq;
    st.takeExc  = takeTrap | takeInt;
    st.excIsInt = takeInt;
    st.doEret   = eretReq & ~st.takeExc;
    wrOk        = wrEn & ~st.takeExc & ~eretReq;
    st.wrStatus = wrOk && (regIdx == IDX_W'(STATUS_IDX));
    st.wrCause  = wrOk && (regIdx == IDX_W'(CAUSE_IDX));
    st.wrEpc    = wrOk && (regIdx == IDX_W'(EPC_IDX));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirect       <= 1'b0;
      redirectIsEret <= 1'b0;
    end else begin
      redirect       <= st.takeExc | st.doEret;
      redirectIsEret <= st.doEret;
    end
  end
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  excStrobes_t       st,
  input  logic [CODE_W-1:0] trapCode,
  input  logic [DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] nextPc,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] causeQ,
  output logic [DATA_W-1:0] epcQ
);
  localparam int STAT_W   = 4;
  localparam int CODE_LSB = 2;
  localparam int CODE_MSB = CODE_LSB + CODE_W - 1;
  localparam int SW_LSB   = 8;
  localparam int SW_W     = 2;
  localparam int SW_MSB   = SW_LSB + SW_W - 1;

  logic [STAT_W-1:0] statBits;
  logic [CODE_W-1:0] codeQ;
  logic [SW_W-1:0]   swQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statBits <= '0;
      codeQ    <= '0;
      swQ      <= '0;
      epcQ     <= '0;
    end else if (st.takeExc) begin
      statBits <= {statBits[1:0], 2'b00};
      codeQ    <= st.excIsInt ? '0 : trapCode;
      epcQ     <= st.excIsInt ? nextPc : curPc;
    end else if (st.doEret) begin
      statBits[1:0] <= statBits[3:2];
    end else begin
      if (st.wrStatus) statBits <= wrData[STAT_W-1:0];
      if (st.wrCause)  swQ      <= wrData[SW_MSB:SW_LSB];
      if (st.wrEpc)    epcQ     <= wrData;
    end
  end

  always_comb begin
    statusQ                    = '0;
    statusQ[STAT_W-1:0]        = statBits;
    causeQ                     = '0;
    causeQ[CODE_MSB:CODE_LSB]  = codeQ;
    causeQ[SW_MSB:SW_LSB]      = swQ;
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              IDX_W      = 5,
  parameter int              CODE_W     = 5,
  parameter logic [31:0]     VECTOR     = 32'h8000_0080,
  parameter int              STATUS_IDX = 12,
  parameter int              CAUSE_IDX  = 13,
  parameter int              EPC_IDX    = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              boundary,
  input  logic [DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] nextPc,
  input  logic              trapReq,
  input  logic [CODE_W-1:0] trapCode,
  input  logic              intReq,
  input  logic              eretReq,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              redirect,
  output logic [DATA_W-1:0] redirectPc
);
  excStrobes_t       st;
  logic              redirectIsEret;
  logic [DATA_W-1:0] statusQ, causeQ, epcQ;

  exc_ctl #(
    .IDX_W(IDX_W), .STATUS_IDX(STATUS_IDX), .CAUSE_IDX(CAUSE_IDX), .EPC_IDX(EPC_IDX)
  ) uCtl (
    .clk(clk), .rstN(rstN), .boundary(boundary), .trapReq(trapReq),
    .intReq(intReq), .eretReq(eretReq), .wrEn(wrEn), .regIdx(regIdx),
    .ieQ(statusQ[0]), .st(st), .redirect(redirect), .redirectIsEret(redirectIsEret)
  );

  exc_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W)) uRegs (
    .clk(clk), .rstN(rstN), .st(st), .trapCode(trapCode), .curPc(curPc),
    .nextPc(nextPc), .wrData(wrData), .statusQ(statusQ), .causeQ(causeQ), .epcQ(epcQ)
  );

  always_comb begin
    redirectPc = redirectIsEret ? epcQ : DATA_W'(VECTOR);
    if (regIdx == IDX_W'(STATUS_IDX))     rdData = statusQ;
    else if (regIdx == IDX_W'(CAUSE_IDX)) rdData = causeQ;
    else if (regIdx == IDX_W'(EPC_IDX))   rdData = epcQ;
    else                                  rdData = '0;
  end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int          DATA_W = 32,
  parameter int          CODE_W = 5,
  parameter logic [31:0] VECTOR = 32'h8000_0080
) (
  input logic              clk,
  input logic              rstN,
  input logic              boundary,
  input logic [DATA_W-1:0] curPc,
  input logic [DATA_W-1:0] nextPc,
  input logic              trapReq,
  input logic [CODE_W-1:0] trapCode,
  input logic              intReq,
  input logic              eretReq,
  input logic              redirect,
  input logic [DATA_W-1:0] redirectPc,
  input logic [DATA_W-1:0] statusQ,
  input logic [DATA_W-1:0] causeQ,
  input logic [DATA_W-1:0] epcQ
);
  localparam logic [DATA_W-1:0] CAUSE_MASK = DATA_W'(32'h0000_037C);

  // R2
  trap_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && trapReq) |=> (causeQ[6:2] == $past(trapCode)) && (epcQ == $past(curPc))
      && (statusQ[1:0] == 2'b00) && redirect && (redirectPc == DATA_W'(VECTOR)));

  // R3
  int_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && intReq && !trapReq && statusQ[0]) |=>
      (causeQ[6:2] == '0) && (epcQ == $past(nextPc)) && (statusQ[1:0] == 2'b00) && redirect);

  // R4
  int_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && intReq && !trapReq && !statusQ[0] && !eretReq) |=> !redirect);

  // R6
  eret_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eretReq && !(boundary && trapReq) && !(boundary && intReq && statusQ[0])) |=>
      (statusQ[1:0] == $past(statusQ[3:2])) && redirect && (redirectPc == epcQ));

  // R7
  cause_zero_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((causeQ & ~CAUSE_MASK) == '0) && (statusQ[DATA_W-1:4] == '0));

  // R9
  redirect_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(boundary && trapReq) && !(boundary && intReq && statusQ[0]) && !eretReq) |=> !redirect);
endmodule

bind exc_ctrl exc_ctrl_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W), .VECTOR(VECTOR)) uChk (
  .clk(clk), .rstN(rstN), .boundary(boundary), .curPc(curPc), .nextPc(nextPc),
  .trapReq(trapReq), .trapCode(trapCode), .intReq(intReq), .eretReq(eretReq),
  .redirect(redirect), .redirectPc(redirectPc), .statusQ(statusQ), .causeQ(causeQ),
  .epcQ(epcQ)
);

// File: tb/sim_exc_ctrl.sv
module sim_exc_ctrl;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] VEC        = 32'h8000_0080;
  localparam int          WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        boundary = 0, trapReq = 0, intReq = 0, eretReq = 0, wrEn = 0;
  logic [4:0]  trapCode = '0, regIdx = '0;
  logic [31:0] curPc = '0, nextPc = '0, wrData = '0;
  logic [31:0] rdData, redirectPc;
  logic        redirect;

  int checks = 0, fails = 0;
  bit done = 0;

  // Reference model state
  logic [31:0] mS = '0, mC = '0, mE = '0;
  logic        expRed = 0;
  logic [31:0] expRedPc = '0;

  exc_ctrl u0 (
    .clk(clk), .rstN(rstN), .boundary(boundary), .curPc(curPc), .nextPc(nextPc),
    .trapReq(trapReq), .trapCode(trapCode), .intReq(intReq), .eretReq(eretReq),
    .wrEn(wrEn), .regIdx(regIdx), .wrData(wrData), .rdData(rdData),
    .redirect(redirect), .redirectPc(redirectPc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] readRef(input logic [4:0] idx);
    if (idx == 5'd12) return mS;
    if (idx == 5'd13) return mC;
    if (idx == 5'd14) return mE;
    return '0;
  endfunction

  // Reads all three registers plus one unused index through the move-from port
  task automatic readAll(input string tag);
    boundary = 0; trapReq = 0; eretReq = 0; wrEn = 0;
    regIdx = 5'd12; #1 chk({tag, " status"}, rdData, readRef(5'd12));
    regIdx = 5'd13; #1 chk({tag, " cause"}, rdData, readRef(5'd13));
    regIdx = 5'd14; #1 chk({tag, " epc"}, rdData, readRef(5'd14));
    regIdx = 5'd7;  #1 chk({tag, " R7 unused idx"}, rdData, 32'h0);
  endtask

  task automatic step(input string tag, input logic b, input logic t,
                      input logic [4:0] code, input logic i, input logic e,
                      input logic w, input logic [4:0] idx, input logic [31:0] wd,
                      input logic [31:0] pc);
    logic takeT, takeI, exc, er, wr;
    @(negedge clk);
    boundary = b; trapReq = t; trapCode = code; intReq = i; eretReq = e;
    wrEn = w; regIdx = idx; wrData = wd; curPc = pc; nextPc = pc + 32'd4;
    takeT = b & t;
    takeI = b & i & mS[0] & ~t;
    exc   = takeT | takeI;
    er    = e & ~exc;
    wr    = w & ~exc & ~e;
    if (exc) begin
      mC[6:2] = takeI ? 5'd0 : code;
      mE      = takeI ? pc + 32'd4 : pc;
      mS      = {28'h0, mS[1:0], 2'b00};
    end else if (er) begin
      mS[1:0] = mS[3:2];
    end else if (wr) begin
      if (idx == 5'd12) mS = {28'h0, wd[3:0]};
      if (idx == 5'd13) mC[9:8] = wd[9:8];
      if (idx == 5'd14) mE = wd;
    end
    expRed   = exc | er;
    expRedPc = exc ? VEC : mE;
    @(posedge clk);
    #1;
    chk({tag, " R9 redirect"}, {31'h0, redirect}, {31'h0, expRed});
    if (expRed) chk({tag, " R9 redirectPc"}, redirectPc, expRedPc);
    readAll(tag);
  endtask

  initial begin : watchdog
    int n = 0;
    while (!done && n < WATCHDOG) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired: actual %0d expected <%0d", n, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 chk("R1 redirect after reset", {31'h0, redirect}, 32'h0);
    readAll("R1 reset");
    @(negedge clk) rstN = 1;

    // R8: enable interrupts, kernel mode; cause write only bits 9..8; epc write
    step("R8 status write", 0, 0, 0, 0, 0, 1, 5'd12, 32'hFFFF_FFF1, 32'h100);
    step("R8 cause write", 0, 0, 0, 0, 0, 1, 5'd13, 32'hFFFF_FFFF, 32'h104);
    step("R8 epc write", 0, 0, 0, 0, 0, 1, 5'd14, 32'hDEAD_BEE0, 32'h108);
    step("R8 write other idx", 0, 0, 0, 0, 0, 1, 5'd3, 32'hFFFF_FFFF, 32'h10C);
    // R5 R10: trap, enabled interrupt, move-to and return on one boundary
    step("R5 R10 trap wins", 1, 1, 5'd8, 1, 1, 1, 5'd14, 32'h1234_5678, 32'h200);
    // R4: interrupt held while masked
    step("R4 masked int", 1, 0, 0, 1, 0, 0, 5'd0, 0, 32'h8000_0080);
    // R6: return restores enable
    step("R6 eret", 0, 0, 0, 1, 1, 0, 5'd0, 0, 32'h8000_0084);
    // R3 R5: pending interrupt taken at next boundary
    step("R3 R5 int taken", 1, 0, 0, 1, 0, 0, 5'd0, 0, 32'h300);
    step("R6 eret2", 0, 0, 0, 0, 1, 0, 5'd0, 0, 32'h8000_0090);
    // R2: trap codes
    step("R2 trap code 4", 1, 1, 5'd4, 0, 0, 0, 5'd0, 0, 32'h400);
    step("R6 eret3", 0, 0, 0, 0, 1, 0, 5'd0, 0, 32'h8000_0094);
    step("R2 trap code 12", 1, 1, 5'd12, 0, 0, 0, 5'd0, 0, 32'h500);
    // R10: eret beats move-to
    step("R10 eret beats write", 0, 0, 0, 0, 1, 1, 5'd12, 32'h0, 32'h504);
    // R4: no boundary means no interrupt even when enabled
    step("R4 no boundary", 0, 0, 0, 1, 0, 0, 5'd0, 0, 32'h508);

    for (int k = 0; k < 400; k++) begin
      logic [4:0] idxSel;
      case ($urandom % 4)
        0: idxSel = 5'd12;
        1: idxSel = 5'd13;
        2: idxSel = 5'd14;
        default: idxSel = 5'($urandom);
      endcase
      step("R2 R3 R6 R8 R10 random", 1'($urandom % 2), 1'(($urandom % 5) == 0),
           5'($urandom), 1'($urandom % 2), 1'(($urandom % 6) == 0),
           1'(($urandom % 3) == 0), idxSel, $urandom, {$urandom, 2'b00} >> 2 << 2);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule